// File: doc/BRIEF.md
# Sequential Stream Prefetch Buffer

This block sits next to a cache and runs ahead of it along consecutive block addresses. When the cache reports a miss that the buffer cannot serve, the buffer drops whatever it holds and starts a new stream. The stream begins one block past the missing address. It then keeps asking memory for the following blocks until DEPTH entries are either waiting for data or already filled.

Each entry holds a block address and a data word. On a later cache miss, only the oldest entry (the head) is compared with the requested address. The head serves the request only if its data has already come back from memory. A match pops the head, returns its data with a one-cycle hit pulse, and frees a slot, which is refilled with the next sequential request.

The memory side has two channels. Requests use a valid/ready channel. Responses arrive in the order the requests were issued. Responses that belong to a stream that has since been flushed are counted and thrown away, so they never land in the new stream.

Top module: `stream_prefetch_buffer`

## Requirements
- R1: After reset, `hitValid` and `memReqValid` are 0, and no request is made before the first miss strobe.
- R2: A miss strobe that does not hit starts a new stream. The requests that follow carry the addresses missAddr+1, missAddr+2, and so on, in that order.
- R3: At most DEPTH blocks (default 4) belong to the current stream at once, counting both outstanding and filled blocks. With all DEPTH slots taken, `memReqValid` stays 0.
- R4: A miss strobe whose address equals the head entry's address, with that entry's data already returned, raises `hitValid` for exactly one cycle, in the cycle after the strobe. `hitData` then holds that block's response data.
- R5: A head entry whose response has not yet arrived never reports a hit. A miss on its address flushes the buffer and starts a new stream.
- R6: Only the head entry is compared. A miss that matches a younger entry but not the head gives no hit and flushes the buffer.
- R7: After a hit pops the head, one new request is issued, for the address one past the last block requested.
- R8: Responses fill entries in request order, so successive hits along a stream return the data of each block in turn.
- R9: Responses still outstanding from a flushed stream are discarded and never supply data to a later hit.
- R10: `memReqValid` is 0 in any cycle where `missValid` is 1. A request not yet accepted keeps `memReqValid` high and `memReqAddr` unchanged until `memReqReady` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| missValid | input | 1 | Cache miss strobe |
| missAddr | input | ADDR_W | Block address of the cache miss |
| hitValid | output | 1 | One-cycle pulse: the buffer served the miss |
| hitData | output | DATA_W | Data returned on a buffer hit |
| memReqValid | output | 1 | Memory request valid |
| memReqAddr | output | ADDR_W | Block address requested from memory |
| memReqReady | input | 1 | Memory accepts the request |
| memRespValid | input | 1 | In-order memory response valid |
| memRespData | input | DATA_W | Memory response data |

## Verification
A hit is due one cycle after its miss strobe, so the bench drives the strobe at a falling edge and samples `hitValid` and `hitData` at the next falling edge. It then samples one edge later to confirm the pulse has ended. The first request of a new stream leaves the block two cycles after the strobe. The bench's memory model logs handshakes just after each falling edge and answers, at the earliest, on the following edge. Request counts and addresses are therefore compared only after a settling window longer than the refill takes. Deliberately held-back responses let the bench place a lookup on an entry that is still outstanding, and place stale data ahead of the new stream's data.

// File: rtl/spb_pkg.sv
package spb_pkg;
  // Strobes from the control to the datapath, all valid in the same cycle.
  typedef struct packed {
    logic flush;  // drop all entries, restart the stream at missAddr + 1
    logic pop;    // head matched and filled: return its data
    logic alloc;  // request accepted: tag the allocation slot
    logic fill;   // response for the current stream: write data
  } spb_ctrl_t;
endpackage

// File: rtl/spb_control.sv
module spb_control
  import spb_pkg::*;
#(
  parameter int DEPTH   = 4,
  parameter int MAX_OUT = 2 * DEPTH,
  localparam int PTR_W  = $clog2(DEPTH),
  localparam int CNT_W  = $clog2(DEPTH + 1),
  localparam int OUT_W  = $clog2(MAX_OUT + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             missValid,
  input  logic             headMatch,
  input  logic             memReqReady,
  input  logic             memRespValid,
  output spb_ctrl_t        ctrl,
  output logic [PTR_W-1:0] headIdx,
  output logic [PTR_W-1:0] allocIdx,
  output logic [PTR_W-1:0] fillIdx,
  output logic             memReqValid
);
  localparam logic [CNT_W-1:0] FULL     = CNT_W'(DEPTH);
  localparam logic [OUT_W-1:0] OUT_LIMIT = OUT_W'(MAX_OUT);

  logic [CNT_W-1:0] allocCnt, filledCnt, inflight;
  logic [OUT_W-1:0] staleCnt, outTotal;
  logic [PTR_W-1:0] headPtr;
  logic             active;
  logic             hit, respStale, respCur;

  assign inflight  = allocCnt - filledCnt;
  assign outTotal  = staleCnt + OUT_W'(inflight);
  assign hit       = missValid && (filledCnt != '0) && headMatch;
  assign respStale = memRespValid && (staleCnt != '0);
  assign respCur   = memRespValid && (staleCnt == '0);

  assign memReqValid = active && !missValid && (allocCnt < FULL) && (outTotal < OUT_LIMIT);

  always_comb begin
    ctrl.pop   = hit;
    ctrl.flush = missValid && !hit;
    ctrl.alloc = memReqValid && memReqReady;
    ctrl.fill  = respCur && !ctrl.flush;
  end

  assign headIdx  = headPtr;
  assign allocIdx = headPtr + PTR_W'(allocCnt);
  assign fillIdx  = headPtr + PTR_W'(filledCnt);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      allocCnt  <= '0;
      filledCnt <= '0;
      headPtr   <= '0;
      staleCnt  <= '0;
      active    <= 1'b0;
    end else if (ctrl.flush) begin
      allocCnt  <= '0;
      filledCnt <= '0;
      headPtr   <= '0;
      staleCnt  <= staleCnt - OUT_W'(respStale) + OUT_W'(inflight) - OUT_W'(respCur);
      active    <= 1'b1;
    end else begin
      allocCnt  <= allocCnt + CNT_W'(ctrl.alloc) - CNT_W'(hit);
      filledCnt <= filledCnt + CNT_W'(ctrl.fill) - CNT_W'(hit);
      headPtr   <= headPtr + PTR_W'(hit);
      staleCnt  <= staleCnt - OUT_W'(respStale);
    end
  end

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rstN)
    allocCnt <= FULL);
  assert_fill_order_R8: assert property (@(posedge clk) disable iff (!rstN)
    filledCnt <= allocCnt);
  assert_quiet_on_miss_R10: assert property (@(posedge clk) disable iff (!rstN)
    missValid |-> !memReqValid);
  assert_resp_owned_R9: assert property (@(posedge clk) disable iff (!rstN)
    memRespValid |-> (outTotal != '0));
endmodule

// File: rtl/spb_datapath.sv
module spb_datapath
  import spb_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 4,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  spb_ctrl_t         ctrl,
  input  logic [PTR_W-1:0]  headIdx,
  input  logic [PTR_W-1:0]  allocIdx,
  input  logic [PTR_W-1:0]  fillIdx,
  input  logic [ADDR_W-1:0] missAddr,
  input  logic [DATA_W-1:0] memRespData,
  output logic              headMatch,
  output logic [ADDR_W-1:0] memReqAddr,
  output logic              hitValid,
  output logic [DATA_W-1:0] hitData
);
  logic [ADDR_W-1:0] tagMem  [DEPTH];
  logic [DATA_W-1:0] dataMem [DEPTH];
  logic [ADDR_W-1:0] nextAddr;

  assign headMatch  = (tagMem[headIdx] == missAddr);
  assign memReqAddr = nextAddr;

  for (genvar e = 0; e < DEPTH; e++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rstN) begin
        tagMem[e]  <= '0;
        dataMem[e] <= '0;
      end else begin
        if (ctrl.alloc && allocIdx == PTR_W'(e)) tagMem[e]  <= nextAddr;
        if (ctrl.fill  && fillIdx  == PTR_W'(e)) dataMem[e] <= memRespData;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      nextAddr <= '0;
      hitValid <= 1'b0;
      hitData  <= '0;
    end else begin
      if (ctrl.flush)      nextAddr <= missAddr + ADDR_W'(1);
      else if (ctrl.alloc) nextAddr <= nextAddr + ADDR_W'(1);
      hitValid <= ctrl.pop;
      if (ctrl.pop) hitData <= dataMem[headIdx];
    end
  end

  assert_seq_addr_R2: assert property (@(posedge clk) disable iff (!rstN)
    ($past(ctrl.alloc) && !$past(ctrl.flush)) |-> (nextAddr == $past(nextAddr) + ADDR_W'(1)));
endmodule

// File: rtl/stream_prefetch_buffer.sv
module stream_prefetch_buffer
  import spb_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 32,
  parameter int DEPTH   = 4,
  parameter int MAX_OUT = 2 * DEPTH,
  localparam int PTR_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              missValid,
  input  logic [ADDR_W-1:0] missAddr,
  output logic              hitValid,
  output logic [DATA_W-1:0] hitData,
  output logic              memReqValid,
  output logic [ADDR_W-1:0] memReqAddr,
  input  logic              memReqReady,
  input  logic              memRespValid,
  input  logic [DATA_W-1:0] memRespData
);
  spb_ctrl_t        ctrl;
  logic [PTR_W-1:0] headIdx, allocIdx, fillIdx;
  logic             headMatch;

  spb_control #(.DEPTH(DEPTH), .MAX_OUT(MAX_OUT)) u_ctrl (
    .clk, .rstN, .missValid, .headMatch, .memReqReady, .memRespValid,
    .ctrl, .headIdx, .allocIdx, .fillIdx, .memReqValid
  );

  spb_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) u_dp (
    .clk, .rstN, .ctrl, .headIdx, .allocIdx, .fillIdx, .missAddr, .memRespData,
    .headMatch, .memReqAddr, .hitValid, .hitData
  );

  assert_hit_after_miss_R4: assert property (@(posedge clk) disable iff (!rstN)
    hitValid |-> $past(missValid));
  assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memReqReady && !missValid) |=>
      (missValid || (memReqValid && $stable(memReqAddr))));
endmodule

// File: tb/stream_prefetch_buffer_test.sv
`timescale 1ns/1ps
module stream_prefetch_buffer_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        missValid = 1'b0;
  logic [15:0] missAddr = '0;
  logic        hitValid;
  logic [31:0] hitData;
  logic        memReqValid;
  logic [15:0] memReqAddr;
  logic        memReqReady = 1'b1;
  logic        memRespValid = 1'b0;
  logic [31:0] memRespData = '0;

  int checks = 0, errors = 0;
  logic [15:0] reqLog [256];
  int reqCount = 0, respCount = 0;
  bit respEnable = 1'b1;

  always #2.5 clk = ~clk;

  stream_prefetch_buffer uut (
    .clk, .rstN, .missValid, .missAddr, .hitValid, .hitData,
    .memReqValid, .memReqAddr, .memReqReady, .memRespValid, .memRespData
  );

  function automatic logic [31:0] blk(input logic [15:0] a);
    return {~a, a};
  endfunction

  // Request logger: a handshake seen here completes at the next rising edge.
  always @(negedge clk) begin
    #1;
    if (rstN && memReqValid && memReqReady) begin
      reqLog[reqCount] = memReqAddr;
      reqCount++;
    end
  end

  // In-order memory: answers each logged request one per cycle when enabled.
  always @(negedge clk) begin
    if (rstN && respEnable && respCount < reqCount) begin
      memRespValid = 1'b1;
      memRespData  = blk(reqLog[respCount]);
      respCount++;
    end else begin
      memRespValid = 1'b0;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic waitCycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Strobe a miss; return the hit flag and data one cycle later.
  task automatic sendMiss(input logic [15:0] a, output logic hv, output logic [31:0] hd);
    @(negedge clk);
    missValid = 1'b1;
    missAddr  = a;
    #1 check("R10 no request during miss", 32'(memReqValid), 32'd0);
    @(negedge clk);
    missValid = 1'b0;
    hv = hitValid;
    hd = hitData;
  endtask

  task automatic testReset();
    waitCycles(4);
    check("R1 hitValid after reset", 32'(hitValid), 32'd0);
    check("R1 memReqValid after reset", 32'(memReqValid), 32'd0);
    check("R1 no requests before miss", reqCount, 0);
  endtask

  task automatic testStreamAndHit();
    logic hv; logic [31:0] hd; int base;
    base = reqCount;
    sendMiss(16'h0100, hv, hd);
    check("R2 miss on empty buffer gives no hit", 32'(hv), 32'd0);
    waitCycles(12);
    check("R3 exactly DEPTH requests", reqCount - base, 4);
    for (int i = 0; i < 4; i++)
      check("R2 sequential request address", 32'(reqLog[base + i]), 32'(16'h0101 + i));
    check("R3 no request when full", 32'(memReqValid), 32'd0);
    sendMiss(16'h0101, hv, hd);
    check("R4 head hit flag", 32'(hv), 32'd1);
    check("R4 head hit data", hd, blk(16'h0101));
    @(negedge clk);
    check("R4 hit pulse lasts one cycle", 32'(hitValid), 32'd0);
    waitCycles(6);
    check("R7 one refill after pop", reqCount - base, 5);
    check("R7 refill address", 32'(reqLog[base + 4]), 32'h0105);
  endtask

  task automatic testNonHeadMatch();
    logic hv; logic [31:0] hd; int base;
    base = reqCount;
    sendMiss(16'h0103, hv, hd);  // head holds 0x0102
    check("R6 non-head match gives no hit", 32'(hv), 32'd0);
    waitCycles(12);
    check("R6 flush restarts stream", 32'(reqLog[base]), 32'h0104);
    sendMiss(16'h0104, hv, hd);
    check("R6 new stream head hits", 32'(hv), 32'd1);
    check("R6 new stream head data", hd, blk(16'h0104));
  endtask

  task automatic testUnfilledAndStale();
    logic hv; logic [31:0] hd; int base;
    waitCycles(10);
    respEnable = 1'b0;
    base = reqCount;
    sendMiss(16'h0200, hv, hd);
    waitCycles(8);
    check("R5 requests outstanding", reqCount - base, 4);
    sendMiss(16'h0201, hv, hd);
    check("R5 unfilled head does not hit", 32'(hv), 32'd0);
    waitCycles(8);
    check("R5 flush on unfilled head restarts", 32'(reqLog[base + 4]), 32'h0202);
    respEnable = 1'b1;
    waitCycles(16);
    sendMiss(16'h0202, hv, hd);
    check("R9 hit after stale responses", 32'(hv), 32'd1);
    check("R9 stale data discarded", hd, blk(16'h0202));
    sendMiss(16'h0203, hv, hd);
    check("R8 second block in order", hd, blk(16'h0203));
    sendMiss(16'h0204, hv, hd);
    check("R8 third block in order", {31'd0, hv} ^ hd, {31'd0, 1'b1} ^ blk(16'h0204));
  endtask

  task automatic testBackpressure();
    logic hv; logic [31:0] hd; int base;
    waitCycles(10);
    memReqReady = 1'b0;
    base = reqCount;
    sendMiss(16'h0300, hv, hd);
    waitCycles(3);
    check("R10 request held valid", 32'(memReqValid), 32'd1);
    check("R10 request address held", 32'(memReqAddr), 32'h0301);
    waitCycles(2);
    check("R10 held address still stable", 32'(memReqAddr), 32'h0301);
    check("R10 nothing accepted while not ready", reqCount - base, 0);
    memReqReady = 1'b1;
    waitCycles(10);
    check("R10 first accepted address", 32'(reqLog[base]), 32'h0301);
    sendMiss(16'h0301, hv, hd);
    check("R4 hit after backpressure", hd, blk(16'h0301));
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    waitCycles(3);
    rstN = 1'b1;
    testReset();
    testStreamAndHit();
    testNonHeadMatch();
    testUnfilledAndStale();
    testBackpressure();
    waitCycles(4);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule